// File: doc/BRIEF.md
# Branch Record Stack with Freeze

This block keeps a circular stack of the most recent taken-branch records. Each record stores the address the branch left, the address it went to, and a timing field. The timing field counts the clock cycles that passed since the previous record, and it saturates at its maximum value. A branch that is flagged as an interrupt or exception also updates a separate last-exception record. A pointer to the newest entry advances by one on each insertion and wraps around at the stack depth. The records can be read through an indexed read port.

Recording can be frozen by a performance-overflow (buffer-full) event, which keeps the recorded history intact. A build-time mode picks one of two freeze styles:
- **Streamlined:** hardware raises a frozen status flag and leaves the enable bit alone. Software resumes recording by writing a one to a write-one-to-clear status-reset register. Because software never has to write the control register to resume, there is no read-modify-write race with hardware on that register.
- **Legacy:** hardware clears the enable bit, and software has to set it again to resume.

A deep-sleep clear pulse zeroes all records, the last-exception record and the pointer. The enable, freeze-enable and frozen bits keep their values. The first record inserted after such a clear carries a time value of zero.

Top module: `branch_rec_stack`

## Requirements
- R1: After reset, control reads 0, status reads 0, the pointer reads 0, and every record and the last-exception record read zero.
- R2: A recorded branch advances the pointer by one, wrapping from DEPTH-1 to 0. The record at the new pointer value holds that branch's from and to addresses.
- R3: The time field of a record equals the number of clock edges since the previous insertion (or since reset release) at which nothing was inserted. It saturates at 2^TW-1.
- R4: A branch strobe is ignored while the enable bit (register 0, bit 0) is clear, and the pointer stays unchanged.
- R5: In streamlined mode, a freeze event while freeze-on-interrupt (register 0, bit 1) is set does three things. It sets the frozen bit (register 1, bit 0). It leaves the enable bit unchanged. It stops all recording, including a branch strobe in the same cycle.
- R6: Writing 1 to bit 0 of the status-reset register (register 2) clears the frozen bit, and recording resumes. Writing 0 there has no effect. Register 2 always reads 0. If a freeze event and the clear arrive in the same cycle, the freeze wins.
- R7: In legacy mode, a freeze event with freeze-on-interrupt set clears the enable bit and leaves the frozen bit at 0. Recording resumes when software writes the enable bit again. If a control write arrives in the same cycle as the freeze, the freeze wins.
- R8: A freeze event while freeze-on-interrupt is clear has no effect. A branch in the same cycle is still recorded.
- R9: A deep-sleep clear pulse zeroes all records, the last-exception record and the pointer. It keeps the enable, freeze-enable and frozen bits. A branch in the same cycle is not recorded.
- R10: The first record inserted after a deep-sleep clear has a time field of zero.
- R11: A recorded branch with the exception flag set also loads its from and to addresses into the last-exception outputs.
- R12: Register 3 reads the pointer. Writes to registers 1 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Taken branch retires this cycle |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| br_exc | input | 1 | Branch is an interrupt or exception |
| frz_evt | input | 1 | Performance overflow / buffer-full event |
| sleep_clr | input | 1 | One-cycle pulse on entry to a state-clearing sleep level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 status reset, 3 pointer |
| reg_wdata | input | 8 | Register write data |
| rec_idx | input | $clog2(DEPTH) | Record read index |
| reg_rdata | output | 8 | Register read data (combinational) |
| rec_from | output | AW | From address of record rec_idx |
| rec_to | output | AW | To address of record rec_idx |
| rec_time | output | TW | Time field of record rec_idx |
| exc_from | output | AW | Last-exception from address |
| exc_to | output | AW | Last-exception to address |

## Verification
The assertions assume that the sleep-clear pulse and the freeze event are single-cycle inputs. They also assume that, in the cycles they examine, no control write coincides with a freeze or a sleep clear; otherwise the expected state of the control and status bits would be ambiguous. The bench drives every input at the falling edge and issues each register write in its own cycle. It places freeze events and sleep clears in cycles with no control write, so every assertion precondition is either met cleanly or not triggered. A second instance built in legacy mode shares all inputs with the first, so both freeze styles see the same event sequence.

// File: rtl/branch_rec_stack.sv
`timescale 1ns/1ps
module branch_rec_stack #(
  parameter int DEPTH  = 16,
  parameter int AW     = 32,
  parameter int TW     = 8,
  parameter bit LEGACY = 1'b0,
  localparam int PW    = $clog2(DEPTH),
  localparam int RW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_from,
  input  logic [AW-1:0] br_to,
  input  logic          br_exc,
  input  logic          frz_evt,
  input  logic          sleep_clr,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic [PW-1:0] rec_idx,
  output logic [RW-1:0] reg_rdata,
  output logic [AW-1:0] rec_from,
  output logic [AW-1:0] rec_to,
  output logic [TW-1:0] rec_time,
  output logic [AW-1:0] exc_from,
  output logic [AW-1:0] exc_to
);

  logic          en_q, fe_q, frz_q, zero_q;
  logic [PW-1:0] tos_q;
  logic [TW-1:0] cnt_q;
  logic [AW-1:0] from_m [DEPTH];
  logic [AW-1:0] to_m   [DEPTH];
  logic [TW-1:0] tm_m   [DEPTH];

  wire           frz_hit = frz_evt & fe_q;
  wire           ins     = br_valid & en_q & ~frz_q & ~frz_hit & ~sleep_clr;
  wire           wr_ctrl = reg_we & (reg_addr == 2'd0);
  wire           wr_clr  = reg_we & (reg_addr == 2'd2) & reg_wdata[0];
  wire  [PW-1:0] tos_nx  = (tos_q == PW'(DEPTH-1)) ? '0 : tos_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fe_q  <= 1'b0;
      frz_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q <= reg_wdata[0];
        fe_q <= reg_wdata[1];
      end
      if (LEGACY && frz_hit) en_q <= 1'b0;
      if (!LEGACY && frz_hit) frz_q <= 1'b1;
      else if (wr_clr)        frz_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      if (sleep_clr || ins)  cnt_q <= '0;
      else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
      if (sleep_clr)         zero_q <= 1'b1;
      else if (ins)          zero_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q    <= '0;
      exc_from <= '0;
      exc_to   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        from_m[i] <= '0;
        to_m[i]   <= '0;
        tm_m[i]   <= '0;
      end
    end else if (sleep_clr) begin
      tos_q    <= '0;
      exc_from <= '0;
      exc_to   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        from_m[i] <= '0;
        to_m[i]   <= '0;
        tm_m[i]   <= '0;
      end
    end else if (ins) begin
      tos_q          <= tos_nx;
      from_m[tos_nx] <= br_from;
      to_m[tos_nx]   <= br_to;
      tm_m[tos_nx]   <= zero_q ? '0 : cnt_q;
      if (br_exc) begin
        exc_from <= br_from;
        exc_to   <= br_to;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = RW'({fe_q, en_q});
      2'd1:    reg_rdata = RW'(frz_q);
      2'd3:    reg_rdata = RW'(tos_q);
      default: reg_rdata = '0;
    endcase
  end

  assign rec_from = from_m[rec_idx];
  assign rec_to   = to_m[rec_idx];
  assign rec_time = tm_m[rec_idx];

  assert_ins_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins |=> (tos_q != $past(tos_q)) && (from_m[tos_q] == $past(br_from)));

  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !en_q && !sleep_clr) |=> $stable(tos_q));

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !sleep_clr) |=> $stable(tos_q));

  assert_sleep_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_clr && !reg_we && !frz_evt) |=>
      (tos_q == '0) && (exc_from == '0) && $stable(en_q) && $stable(frz_q));

  generate
    if (LEGACY) begin : g_leg
      assert_legacy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_evt && fe_q) |=> (!en_q && !frz_q));
    end else begin : g_str
      assert_freeze_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_evt && fe_q && !wr_ctrl) |=> (frz_q && $stable(en_q)));
    end
  endgenerate

endmodule

// File: tb/test_branch_rec_stack.sv
`timescale 1ns/1ps
module test_branch_rec_stack;

  typedef struct packed {
    logic [3:0]  s;
    logic [31:0] f;
    logic [31:0] t;
    logic [7:0]  tm;
    logic        z;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 0, br_exc = 0, frz_evt = 0, sleep_clr = 0, reg_we = 0;
  logic [31:0] br_from = '0, br_to = '0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [3:0]  rec_idx = '0;
  logic [7:0]  rdata, l_rdata;
  logic [31:0] rec_from, rec_to, exc_from, exc_to;
  logic [7:0]  rec_time;
  logic [31:0] l_f, l_t, l_ef, l_et;
  logic [7:0]  l_tm;
  logic [3:0]  l_idx = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  bit       m_en = 0, m_fe = 0, m_frz = 0, zero_next = 0;
  int       m_tos = 0, idle = 0;
  logic [31:0] last_f, last_t;

  always #2.5 clk = ~clk;

  branch_rec_stack i_branch_rec_stack (
    .clk, .rst_n, .br_valid, .br_from, .br_to, .br_exc, .frz_evt, .sleep_clr,
    .reg_we, .reg_addr, .reg_wdata, .rec_idx, .reg_rdata(rdata),
    .rec_from, .rec_to, .rec_time, .exc_from, .exc_to);

  branch_rec_stack #(.LEGACY(1'b1)) i_branch_rec_stack_leg (
    .clk, .rst_n, .br_valid, .br_from, .br_to, .br_exc, .frz_evt, .sleep_clr,
    .reg_we, .reg_addr, .reg_wdata, .rec_idx(l_idx), .reg_rdata(l_rdata),
    .rec_from(l_f), .rec_to(l_t), .rec_time(l_tm), .exc_from(l_ef), .exc_to(l_et));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] f, input logic [31:0] t,
                     input logic e, input logic p, input logic c,
                     input logic w, input logic [1:0] a, input logic [7:0] d);
    bit ins;
    int nt;
    br_valid = v; br_from = f; br_to = t; br_exc = e; frz_evt = p;
    sleep_clr = c; reg_we = w; reg_addr = a; reg_wdata = d;
    ins = v && m_en && !m_frz && !(p && m_fe) && !c;
    nt = (m_tos == 15) ? 0 : m_tos + 1;
    if (ins) begin
      q.push_back('{s: 4'(nt), f: f, t: t, tm: zero_next ? 8'd0 : 8'(idle), z: zero_next});
      last_f = f; last_t = t;
    end
    @(posedge clk);
    if (c) begin m_tos = 0; idle = 0; zero_next = 1; end
    else if (ins) begin m_tos = nt; idle = 0; zero_next = 0; end
    else if (idle < 255) idle++;
    if (w && a == 2'd0) begin m_en = d[0]; m_fe = d[1]; end
    if (p && m_fe) m_frz = 1;
    else if (w && a == 2'd2 && d[0]) m_frz = 0;
    @(negedge clk);
    br_valid = 0; frz_evt = 0; sleep_clr = 0; reg_we = 0; br_exc = 0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic br(input logic [31:0] f, input logic [31:0] t, input logic e = 0, input logic p = 0);
    cyc(1, f, t, e, p, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; #0.1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic rdl(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; #0.1;
    chk(tag, 32'(l_rdata), 32'(exp));
  endtask

  task automatic recx(input int idx, input logic [31:0] f, input logic [31:0] t, input string tag);
    rec_idx = 4'(idx); #0.1;
    chk({tag, " from"}, rec_from, f);
    chk({tag, " to"}, rec_to, t);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        rec_idx = e.s; #0.2;
        chk("R2 record from", rec_from, e.f);
        chk("R2 record to", rec_to, e.t);
        chk(e.z ? "R10 time after sleep" : "R3 time field", 32'(rec_time), 32'(e.tm));
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 ctrl"); rd(1, 0, "R1 status"); rd(3, 0, "R1 pointer");
    recx(5, 0, 0, "R1 record");
    chk("R1 exc_from", exc_from, 0);
    // R4 disabled
    br(32'h100, 32'h200);
    rd(3, 0, "R4 pointer while disabled");
    wr(0, 8'h03);
    idle_n(3);
    br(32'h1000, 32'h2000);
    br(32'h1004, 32'h2004);
    idle_n(300);
    br(32'h1008, 32'h2008, 1);
    chk("R11 exc_from", exc_from, 32'h1008);
    chk("R11 exc_to", exc_to, 32'h2008);
    for (int i = 0; i < 14; i++) begin
      idle_n(i % 3);
      br(32'h3000 + 32'(i), 32'h4000 + 32'(i));
    end
    rd(3, 8'd1, "R2 pointer wrap");
    recx(1, 32'h300d, 32'h400d, "R2 wrapped slot");
    // R5 freeze with same-cycle branch
    br(32'hdead, 32'hbeef, 0, 1);
    rd(1, 8'h01, "R5 frozen set"); rd(0, 8'h03, "R5 enable kept");
    rd(3, 8'd1, "R5 same-cycle branch dropped");
    rdl(0, 8'h02, "R7 legacy enable cleared"); rdl(1, 8'h00, "R7 legacy frozen stays 0");
    br(32'h5000, 32'h6000);
    rd(3, 8'd1, "R5 pointer while frozen");
    recx(1, last_f, last_t, "R5 newest unchanged");
    // R6 unfreeze
    wr(2, 8'h00);
    rd(1, 8'h01, "R6 zero write no effect");
    wr(2, 8'h01);
    rd(1, 8'h00, "R6 frozen cleared"); rd(0, 8'h03, "R6 ctrl untouched");
    rd(2, 8'h00, "R6 reset reg reads 0");
    wr(0, 8'h03);
    rdl(0, 8'h03, "R7 legacy enable restored");
    br(32'h7000, 32'h8000);
    rd(3, 8'd2, "R6 recording resumed");
    // R8 freeze disabled
    wr(0, 8'h01);
    br(32'h7100, 32'h8100, 0, 1);
    rd(1, 8'h00, "R8 no freeze"); rd(3, 8'd3, "R8 branch recorded");
    // R12 register map
    wr(3, 8'h55); rd(3, 8'd3, "R12 pointer write ignored");
    wr(1, 8'hff); rd(1, 8'h00, "R12 status write ignored");
    // R9 sleep clear
    wr(0, 8'h03);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    rd(1, 8'h01, "R9 frozen before sleep");
    cyc(1, 32'h9999, 32'h9999, 1, 0, 1, 0, 0, 0);
    rd(3, 8'd0, "R9 pointer cleared"); rd(1, 8'h01, "R9 frozen kept");
    rd(0, 8'h03, "R9 ctrl kept");
    recx(3, 0, 0, "R9 record cleared");
    chk("R9 exc cleared", exc_from, 0);
    wr(2, 8'h01);
    idle_n(7);
    br(32'hA000, 32'hB000);
    rd(3, 8'd1, "R10 first slot after sleep");
    idle_n(4);
    br(32'hA004, 32'hB004);
    idle_n(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule